// File: doc/BRIEF.md
# Page Write Staging Buffer

This block collects the data bytes of one page-write transaction for a byte-addressed non-volatile array. A protocol engine loads a starting address and then delivers data bytes one at a time. Each byte lands at the low offset of the address pointer, and only that offset advances, so a long or misaligned burst wraps around inside the same 64-byte page. A later byte at an offset that already holds data replaces the earlier one.

The array is not touched until the engine issues a commit. The block then runs a read-modify-write over every offset of the page in ascending order. It reads each location and writes back either the staged byte or the value it just read. Bytes that were not written in the transaction are therefore refreshed rather than skipped. Busy stays high for the sweep and for a fixed settle period after it, and all engine requests are ignored during that time. A discard request drops the staged data without any array access. The engine uses it when protection was active or the transaction ended without a proper stop.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy_o is low, ptr_o is zero and neither array strobe is asserted.
- R2: An accepted start_i loads ptr_o with start_addr_i on the next cycle and clears every staged byte and mark.
- R3: An accepted data byte is staged at offset ptr_o[5:0]. Then only ptr_o[5:0] increments, modulo 64, and ptr_o[14:6] keeps its value, so offset 63 is followed by offset 0 of the same page.
- R4: When more than 64 bytes arrive in one transaction, a later byte at an offset replaces the earlier byte staged there.
- R5: No array write occurs before a commit is accepted, and arr_we_o is never high while busy_o is low.
- R6: An accepted commit raises busy_o on the next cycle. For each offset 0 to 63 in turn, the block spends one cycle with arr_re_o high and then one cycle with arr_we_o high, with the same address {ptr_o[14:6], offset} in both. arr_rdata_i is taken to hold the read data in the cycle after arr_re_o.
- R7: The value written at each offset is the staged byte if that offset received data in the transaction, and the value read from the array otherwise.
- R8: busy_o stays high for exactly 2*64 + HOLD_CYCLES cycles after a commit is accepted. Afterwards the staging marks are clear.
- R9: While busy_o is high, start_i, data_valid_i, commit_i and discard_i are ignored. ptr_o and the staged contents do not change.
- R10: An accepted discard clears all staged bytes and marks, causes no array access, and leaves ptr_o unchanged.
- R11: After a commit, ptr_o equals the page base plus the final wrapped offset of the transaction.
- R12: When several requests arrive together while idle, start_i wins over commit_i, commit_i wins over discard_i, and discard_i wins over data_valid_i. Only the winning request takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction at start_addr_i |
| start_addr_i | input | ADDR_W | Starting byte address |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Write staged page to the array |
| discard_i | input | 1 | Drop staged data without writing |
| busy_o | output | 1 | Commit sweep or settle period in progress |
| ptr_o | output | ADDR_W | Current address pointer |
| arr_addr_o | output | ADDR_W | Array address |
| arr_re_o | output | 1 | Array read strobe |
| arr_rdata_i | input | DATA_W | Array read data, valid the cycle after arr_re_o |
| arr_we_o | output | 1 | Array write strobe |
| arr_wdata_o | output | DATA_W | Array write data |

## Verification
Pointer updates from start and data strobes show on ptr_o one cycle after the accepting edge. busy_o rises one cycle after a commit. The array model returns read data one cycle after arr_re_o, and the merged byte is written in the following cycle. The bench drives every request on the falling edge and samples on the next falling edge. It counts falling edges with busy_o high and expects 2*64 + HOLD_CYCLES. Only after busy_o falls does it compare the whole page of its array model with the page it computed at the moment of commit. Its write monitor checks the order and the read-before-write pairing on every array write.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2,
    SEQ_HOLD  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int BASE_W = ADDR_W - OFS_W;
  localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);

  logic [BASE_W-1:0] base_q;
  logic [OFS_W-1:0]  ofs_q;

  // base is frozen for the whole transaction; only the offset wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ofs_q  <= '0;
    end else if (load_i) begin
      base_q <= load_addr_i[ADDR_W-1:OFS_W];
      ofs_q  <= load_addr_i[OFS_W-1:0];
    end else if (step_i) begin
      ofs_q  <= ofs_q + OFS_ONE;
    end
  end

  assign ptr_o = {base_q, ofs_q};
endmodule

// File: rtl/pwb_stage.sv
module pwb_stage #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int OFS_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic              mark_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_ofs_i == OFS_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        mark_q[g] <= 1'b0;
      end else if (clr_i) begin
        data_q[g] <= '0;
        mark_q[g] <= 1'b0;
      end else if (sel) begin
        data_q[g] <= wr_data_i;
        mark_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_ofs_i];
  assign rd_hit_o  = mark_q[rd_ofs_i];
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int OFS_W       = 6,
  parameter int DEPTH       = 64,
  parameter int HOLD_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  output logic             busy_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             done_o,
  output logic [OFS_W-1:0] idx_o
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [OFS_W-1:0]  LAST_IDX = OFS_W'(DEPTH - 1);
  localparam logic [OFS_W-1:0]  IDX_ONE  = OFS_W'(1);
  localparam logic [HOLD_W-1:0] HOLD_INI = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);

  seq_state_e        state_q;
  logic [OFS_W-1:0]  idx_q;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (go_i) begin
          state_q <= SEQ_READ;
          idx_q   <= '0;
        end
        SEQ_READ: state_q <= SEQ_WRITE;
        SEQ_WRITE: begin
          if (idx_q == LAST_IDX) begin
            state_q <= SEQ_HOLD;
            hold_q  <= HOLD_INI;
          end else begin
            idx_q   <= idx_q + IDX_ONE;
            state_q <= SEQ_READ;
          end
        end
        SEQ_HOLD: begin
          if (hold_q == '0) state_q <= SEQ_IDLE;
          else              hold_q  <= hold_q - HOLD_ONE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);
  assign rd_o   = (state_q == SEQ_READ);
  assign wr_o   = (state_q == SEQ_WRITE);
  assign done_o = (state_q == SEQ_HOLD) && (hold_q == '0);
  assign idx_o  = idx_q;
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              discard_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic              arr_re_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              arr_we_o,
  output logic [DATA_W-1:0] arr_wdata_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic             busy, seq_rd, seq_wr, seq_done;
  logic [OFS_W-1:0] seq_idx;
  logic             start_acc, commit_acc, discard_acc, data_acc;
  logic [DATA_W-1:0] stg_data;
  logic             stg_hit;

  // fixed precedence: start > commit > discard > data, all gated by idle
  always_comb begin
    start_acc   = !busy && start_i;
    commit_acc  = !busy && !start_i && commit_i;
    discard_acc = !busy && !start_i && !commit_i && discard_i;
    data_acc    = !busy && !start_i && !commit_i && !discard_i && data_valid_i;
  end

  pwb_pointer #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_acc),
    .load_addr_i (start_addr_i),
    .step_i      (data_acc),
    .ptr_o       (ptr_o)
  );

  pwb_stage #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .OFS_W(OFS_W)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_acc || discard_acc || seq_done),
    .wr_en_i   (data_acc),
    .wr_ofs_i  (ptr_o[OFS_W-1:0]),
    .wr_data_i (data_i),
    .rd_ofs_i  (seq_idx),
    .rd_data_o (stg_data),
    .rd_hit_o  (stg_hit)
  );

  pwb_seq #(.OFS_W(OFS_W), .DEPTH(PAGE_BYTES), .HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (commit_acc),
    .busy_o (busy),
    .rd_o   (seq_rd),
    .wr_o   (seq_wr),
    .done_o (seq_done),
    .idx_o  (seq_idx)
  );

  assign busy_o      = busy;
  assign arr_addr_o  = {ptr_o[ADDR_W-1:OFS_W], seq_idx};
  assign arr_re_o    = seq_rd;
  assign arr_we_o    = seq_wr;
  // untouched offsets are refreshed with what the array returned
  assign arr_wdata_o = stg_hit ? stg_data : arr_rdata_i;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              data_valid_i,
  input logic              commit_i,
  input logic              discard_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              arr_re_o,
  input logic              arr_we_o
);
  localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);

  AST_WE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o); // R5

  AST_RE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_re_o && arr_we_o)); // R6

  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_re_o |=> (arr_we_o && $stable(arr_addr_o))); // R6

  AST_PAGE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_re_o || arr_we_o) |-> (arr_addr_o[ADDR_W-1:OFS_W] == ptr_o[ADDR_W-1:OFS_W])); // R6

  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && commit_i && !start_i) |=> busy_o); // R6

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ptr_o)); // R9

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (ptr_o == $past(start_addr_i))); // R2

  AST_OFS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && data_valid_i && !start_i && !commit_i && !discard_i) |=>
      ((ptr_o[ADDR_W-1:OFS_W] == $past(ptr_o[ADDR_W-1:OFS_W])) &&
       (ptr_o[OFS_W-1:0] == $past(ptr_o[OFS_W-1:0]) + OFS_ONE))); // R3

  AST_DISCARD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && discard_i && !start_i && !commit_i) |=>
      (!busy_o && !arr_we_o && $stable(ptr_o))); // R10
endmodule

bind page_write_buffer pwb_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_pwb_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .data_valid_i (data_valid_i),
  .commit_i     (commit_i),
  .discard_i    (discard_i),
  .busy_o       (busy_o),
  .ptr_o        (ptr_o),
  .arr_addr_o   (arr_addr_o),
  .arr_re_o     (arr_re_o),
  .arr_we_o     (arr_we_o)
);

// File: tb/page_write_buffer_bench.sv
`timescale 1ns/1ps
module page_write_buffer_bench;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int PAGE   = 64;
  localparam int HOLD   = 16;
  localparam int BUSY_LEN = 2*PAGE + HOLD;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic              data_valid_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              commit_i = 1'b0;
  logic              discard_i = 1'b0;
  logic              busy_o;
  logic [ADDR_W-1:0] ptr_o;
  logic [ADDR_W-1:0] arr_addr_o;
  logic              arr_re_o;
  logic [DATA_W-1:0] arr_rdata = '0;
  logic              arr_we_o;
  logic [DATA_W-1:0] arr_wdata_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  page_write_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .HOLD_CYCLES(HOLD))
    u_page_write_buffer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .data_valid_i(data_valid_i), .data_i(data_i), .commit_i(commit_i), .discard_i(discard_i),
    .busy_o(busy_o), .ptr_o(ptr_o), .arr_addr_o(arr_addr_o), .arr_re_o(arr_re_o),
    .arr_rdata_i(arr_rdata), .arr_we_o(arr_we_o), .arr_wdata_o(arr_wdata_o)
  );

  // sparse array model, synchronous read
  logic [7:0] mem [int];
  function automatic logic [7:0] mem_rd(logic [ADDR_W-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'((int'(a) * 37 + 11) ^ (int'(a) >> 8));
  endfunction

  int               wr_cnt = 0;
  int               mon_err = 0;
  logic [5:0]       mon_idx = '0;
  logic [ADDR_W-1:0] last_rd = '0;

  always @(posedge clk) begin
    if (arr_we_o) begin
      wr_cnt++;
      if (arr_addr_o !== last_rd || arr_addr_o[5:0] !== mon_idx) mon_err++;
      mon_idx = mon_idx + 6'd1;
      mem[int'(arr_addr_o)] = arr_wdata_o;
    end
    if (arr_re_o) begin
      arr_rdata <= mem_rd(arr_addr_o);
      last_rd = arr_addr_o;
    end
  end

  // reference state from the requirements
  logic [7:0]        m_data [PAGE];
  bit                m_mark [PAGE];
  logic [ADDR_W-1:0] m_ptr = '0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < PAGE; k++) begin m_data[k] = '0; m_mark[k] = 1'b0; end
  endtask

  task automatic do_start(logic [ADDR_W-1:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    m_ptr = a; clear_model();
  endtask

  task automatic send_byte(logic [7:0] b);
    data_valid_i = 1'b1; data_i = b;
    @(negedge clk);
    data_valid_i = 1'b0;
    m_data[m_ptr[5:0]] = b; m_mark[m_ptr[5:0]] = 1'b1;
    m_ptr[5:0] = m_ptr[5:0] + 6'd1;
  endtask

  task automatic page_snapshot(output logic [7:0] pg [PAGE], input logic [ADDR_W-1:0] base);
    for (int k = 0; k < PAGE; k++) pg[k] = mem_rd(base | ADDR_W'(k));
  endtask

  task automatic do_commit(string req, bit poke);
    logic [7:0] exp_pg [PAGE];
    logic [ADDR_W-1:0] base;
    int n, bad, w0, first;
    base = {m_ptr[ADDR_W-1:6], 6'd0};
    for (int k = 0; k < PAGE; k++)
      exp_pg[k] = m_mark[k] ? m_data[k] : mem_rd(base | ADDR_W'(k));
    w0 = wr_cnt; mon_err = 0; mon_idx = '0;
    commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
    chk(busy_o == 1'b1, "R6", "busy after commit", busy_o, 1);
    n = 0;
    while (busy_o && n < 10000) begin
      if (poke && n == 20) begin
        start_i = 1'b1; start_addr_i = ~m_ptr; data_valid_i = 1'b1; data_i = 8'hEE;
        discard_i = 1'b1;
      end
      if (poke && n == 22) begin
        start_i = 1'b0; data_valid_i = 1'b0; discard_i = 1'b0; commit_i = 1'b1;
      end
      if (poke && n == 23) commit_i = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(n == BUSY_LEN, "R8", "busy length", n, BUSY_LEN);
    chk(wr_cnt - w0 == PAGE, "R6", "array writes per commit", wr_cnt - w0, PAGE);
    chk(mon_err == 0, "R6", "write order/read pairing errors", mon_err, 0);
    chk(ptr_o == m_ptr, "R11", "pointer after commit", ptr_o, m_ptr);
    bad = 0; first = -1;
    for (int k = 0; k < PAGE; k++)
      if (mem_rd(base | ADDR_W'(k)) !== exp_pg[k]) begin
        bad++; if (first < 0) first = k;
      end
    if (first < 0) first = 0;
    chk(bad == 0, req, $sformatf("page 0x%0h byte %0d", base, first),
        mem_rd(base | ADDR_W'(first)), exp_pg[first]);
    clear_model();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] snap [PAGE];
    logic [7:0] snap2 [PAGE];
    int w0, bad;
    void'($urandom(32'd4242));
    clear_model();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0 && arr_we_o == 1'b0 && arr_re_o == 1'b0, "R1", "strobes in reset",
        {busy_o, arr_we_o, arr_re_o}, 0);
    chk(ptr_o == '0, "R1", "pointer in reset", ptr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && ptr_o == '0, "R1", "state after reset", ptr_o, 0);

    // R2/R3/R5: single byte mid-page
    do_start(15'h1234);
    chk(ptr_o == 15'h1234, "R2", "pointer load", ptr_o, 15'h1234);
    w0 = wr_cnt;
    send_byte(8'hA5);
    chk(ptr_o == 15'h1235, "R3", "pointer step", ptr_o, 15'h1235);
    repeat (5) @(negedge clk);
    chk(wr_cnt == w0, "R5", "writes before commit", wr_cnt - w0, 0);
    do_commit("R7", 1'b0);

    // R3: wrap from offset 60 through 63 to 5 of the same page
    do_start(15'h2A7C);
    for (int i = 0; i < 10; i++) send_byte(8'(8'h30 + i));
    chk(ptr_o == 15'h2A46, "R3", "wrapped pointer", ptr_o, 15'h2A46);
    do_commit("R3", 1'b0);
    chk(mem_rd(15'h2A40) == 8'h34, "R3", "wrapped byte at offset 0", mem_rd(15'h2A40), 8'h34);

    // R4: 70 bytes, later bytes replace offsets 0..5
    do_start(15'h4000);
    for (int i = 0; i < 70; i++) send_byte(8'(i + 1));
    chk(ptr_o == 15'h4006, "R4", "pointer after overflow", ptr_o, 15'h4006);
    do_commit("R4", 1'b0);
    chk(mem_rd(15'h4003) == 8'd68, "R4", "overwritten offset 3", mem_rd(15'h4003), 68);

    // R10: discard drops data without array access
    page_snapshot(snap, 15'h5100);
    do_start(15'h5110);
    for (int i = 0; i < 5; i++) send_byte(8'hC0 + 8'(i));
    w0 = wr_cnt;
    discard_i = 1'b1;
    @(negedge clk);
    discard_i = 1'b0;
    clear_model();
    chk(ptr_o == 15'h5115 && !busy_o, "R10", "pointer after discard", ptr_o, 15'h5115);
    chk(wr_cnt == w0, "R10", "writes on discard", wr_cnt - w0, 0);
    do_commit("R10", 1'b0);
    bad = 0;
    for (int k = 0; k < PAGE; k++) if (mem_rd(15'h5100 | 15'(k)) !== snap[k]) bad++;
    chk(bad == 0, "R10", "page changed after discard", bad, 0);

    // R9: requests during busy are ignored
    do_start(15'h6020);
    for (int i = 0; i < 3; i++) send_byte(8'h5A ^ 8'(i));
    do_commit("R7", 1'b1);
    chk(ptr_o == 15'h6023, "R9", "pointer after busy pokes", ptr_o, 15'h6023);
    chk(!busy_o, "R9", "no commit from poke", busy_o, 0);
    page_snapshot(snap2, 15'h6000);
    do_commit("R9", 1'b0);
    bad = 0;
    for (int k = 0; k < PAGE; k++) if (mem_rd(15'h6000 | 15'(k)) !== snap2[k]) bad++;
    chk(bad == 0, "R9", "staged data from busy pokes", bad, 0);

    // R12: precedence
    start_i = 1'b1; start_addr_i = 15'h7007; data_valid_i = 1'b1; data_i = 8'h11;
    commit_i = 1'b1; discard_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; data_valid_i = 1'b0; commit_i = 1'b0; discard_i = 1'b0;
    m_ptr = 15'h7007; clear_model();
    chk(ptr_o == 15'h7007 && !busy_o, "R12", "start wins", ptr_o, 15'h7007);
    send_byte(8'h99);
    discard_i = 1'b1; data_valid_i = 1'b1; data_i = 8'h22;
    @(negedge clk);
    discard_i = 1'b0; data_valid_i = 1'b0;
    clear_model();
    chk(ptr_o == 15'h7008, "R12", "discard beats data", ptr_o, 15'h7008);
    send_byte(8'h77);
    discard_i = 1'b1;
    do_commit("R12", 1'b0);
    discard_i = 1'b0;
    chk(mem_rd(15'h7008) == 8'h77, "R12", "commit beats discard", mem_rd(15'h7008), 8'h77);

    // random transactions
    for (int t = 0; t < 8; t++) begin
      int len;
      do_start(15'($urandom));
      len = int'($urandom_range(0, 80));
      for (int i = 0; i < len; i++) send_byte(8'($urandom));
      do_commit("R7", 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule